// File: doc/BRIEF.md
# Eight-bit arithmetic and logic unit with per-operation flag rules

This block is the data-processing stage of a small processor core. Each cycle it takes two 8-bit operands, a 4-bit operation code and a 3-bit bit index. It produces the 8-bit result and a write-back strobe within the same cycle, with no register on that path. It also keeps a 4-bit condition register (carry, zero, sign, overflow). That register is loaded on the clock edge of every enabled cycle.

The instruction decoder that surrounds the block drives the operation code. It uses the write-back strobe to decide whether the result goes back to a register. Compare, test and bit-test change only the condition register, so the strobe stays low for them.

Each operation uses its own flag rules:
- Increment and decrement keep carry and overflow.
- The logical operations clear carry and overflow.
- The single-bit operations report the selected bit through carry and leave the other flags alone.
- Add-with-carry and subtract-with-borrow take their extra input from the stored carry.

Top module: `alu8_flags`

## Requirements
- R1: Operation codes 0 (add) and 1 (add with carry) give a + b, plus the stored carry for code 1. Carry is the bit-8 carry out. Overflow is set when both operands have the same sign bit and the result's sign bit differs from it.
- R2: Codes 2 (subtract) and 3 (subtract with borrow) give a - b, minus the stored carry for code 3. Carry is set when a borrow occurs (unsigned a < b + borrow). Overflow is set when the operand sign bits differ and the result's sign bit differs from a's.
- R3: Codes 4 (increment a) and 5 (decrement a) update zero and sign and leave carry and overflow unchanged.
- R4: Code 6 (compare) sets the flags exactly as code 2 does: zero when a equals b, carry when a < b unsigned. It does not assert write-back.
- R5: Codes 7 (AND), 8 (OR) and 9 (test) clear carry and overflow. Test computes a AND b and does not assert write-back. OR of a nonzero value whose bit 7 is 0 with itself leaves all four flags clear.
- R6: Code 10 gives the one's complement of a and updates only zero and sign. Code 11 gives 0 - a. For code 11, carry is set when a is nonzero and overflow is set when a is 8'h80.
- R7: Codes 12 (bit test), 13 (bit set), 14 (bit clear) and 15 (bit invert) act on the bit of a selected by the index (index 0 is the LSB).
  - Carry receives the original value of that bit.
  - The result is a with that bit forced to 1, forced to 0 or inverted, as the code selects. Code 12 returns a unchanged.
  - Zero, sign and overflow are unchanged.
- R8: For every operation with a code below 12, zero is set when the 8-bit result is 0, and sign takes result bit 7.
- R9: Write-back is high exactly when the enable is high and the code is not 6, 9 or 12.
- R10: The flags load on the rising clock edge when the enable is high and hold otherwise. An active-low asynchronous reset clears them.
- R11: The flag output carries carry on bit 0, zero on bit 1, sign on bit 2 and overflow on bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Operation valid this cycle |
| op | input | 4 | Operation code |
| a | input | 8 | First operand |
| b | input | 8 | Second operand |
| bit_idx | input | 3 | Bit selector for the single-bit operations |
| result | output | 8 | Combinational result |
| wr_en | output | 1 | Result write-back strobe |
| flags | output | 4 | Registered flags {V,S,Z,C} |

## Verification
The result and the write-back strobe follow the inputs within the same cycle. The flags change one rising edge after an enabled operation.

The bench drives each operation on a falling edge. It samples the result and the strobe 1 ns later, before the next rising edge, and compares them with a reference computed from the flags the bench holds in its own model. It then waits past the rising edge and compares the flag output. Its model flags advance only for enabled operations, so the hold rule is checked on the same one-edge schedule.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
    typedef enum logic [3:0] {
        OP_ADD = 4'd0,  OP_ADC = 4'd1,  OP_SUB = 4'd2,  OP_SBB = 4'd3,
        OP_INC = 4'd4,  OP_DEC = 4'd5,  OP_CMP = 4'd6,  OP_AND = 4'd7,
        OP_OR  = 4'd8,  OP_TST = 4'd9,  OP_NOT = 4'd10, OP_NEG = 4'd11,
        OP_BT  = 4'd12, OP_BS  = 4'd13, OP_BR  = 4'd14, OP_BC  = 4'd15
    } alu_op_e;

    typedef struct packed {
        logic v;
        logic s;
        logic z;
        logic c;
    } flags_t;

    typedef enum logic [1:0] {
        BM_TEST = 2'd0, BM_SET = 2'd1, BM_CLR = 2'd2, BM_INV = 2'd3
    } bit_mode_e;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         cin,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf
);
    logic [W:0] wide;

    always_comb begin
        if (sub) begin
            wide = {1'b0, x} - {1'b0, y} - {{W{1'b0}}, cin};
            ovf  = (x[W-1] != y[W-1]) && (wide[W-1] != x[W-1]);
        end else begin
            wide = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
            ovf  = (x[W-1] == y[W-1]) && (wide[W-1] != x[W-1]);
        end
        sum  = wide[W-1:0];
        cout = wide[W];
    end
endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops
    import alu8_pkg::*;
#(
    parameter int W    = 8,
    localparam int IW  = $clog2(W)
) (
    input  logic [W-1:0] x,
    input  logic [IW-1:0] idx,
    input  bit_mode_e    mode,
    output logic [W-1:0] res,
    output logic         picked
);
    logic [W-1:0] sel_mask;

    generate
        for (genvar g = 0; g < W; g++) begin : g_mask
            assign sel_mask[g] = (idx == IW'(g));
        end
    endgenerate

    always_comb begin
        picked = |(x & sel_mask);
        unique case (mode)
            BM_SET:  res = x | sel_mask;
            BM_CLR:  res = x & ~sel_mask;
            BM_INV:  res = x ^ sel_mask;
            default: res = x;
        endcase
    end
endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
    import alu8_pkg::*;
#(
    parameter int W   = 8,
    localparam int IW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [3:0]    op,
    input  logic [W-1:0]  a,
    input  logic [W-1:0]  b,
    input  logic [IW-1:0] bit_idx,
    output logic [W-1:0]  result,
    output logic          wr_en,
    output logic [3:0]    flags
);
    typedef struct packed {
        flags_t        fl;
        logic [W-1:0]  res;
        logic          wr;
    } alu_next_t;

    alu_op_e   op_e;
    flags_t    flags_q;
    alu_next_t nx_d;

    logic [W-1:0] as_x, as_y, as_sum, bo_res;
    logic         as_cin, as_sub, as_cout, as_ovf, bo_bit;

    assign op_e = alu_op_e'(op);

    // operand steering for the shared adder/subtractor
    always_comb begin
        as_x   = a;
        as_y   = b;
        as_cin = 1'b0;
        as_sub = 1'b0;
        unique case (op_e)
            OP_ADC:         as_cin = flags_q.c;
            OP_SUB, OP_CMP: as_sub = 1'b1;
            OP_SBB: begin as_sub = 1'b1; as_cin = flags_q.c; end
            OP_INC: begin as_y = '0; as_cin = 1'b1; end
            OP_DEC: begin as_y = '0; as_cin = 1'b1; as_sub = 1'b1; end
            OP_NEG: begin as_x = '0; as_y = a; as_sub = 1'b1; end
            default: ;
        endcase
    end

    alu8_addsub #(.W(W)) u_addsub (
        .x(as_x), .y(as_y), .cin(as_cin), .sub(as_sub),
        .sum(as_sum), .cout(as_cout), .ovf(as_ovf)
    );

    alu8_bitops #(.W(W)) u_bitops (
        .x(a), .idx(bit_idx), .mode(bit_mode_e'(op[1:0])),
        .res(bo_res), .picked(bo_bit)
    );

    always_comb begin
        nx_d.fl  = flags_q;
        nx_d.res = as_sum;
        nx_d.wr  = 1'b1;
        unique case (op_e)
            OP_ADD, OP_ADC, OP_SUB, OP_SBB, OP_CMP, OP_NEG: begin
                nx_d.fl.c = as_cout;
                nx_d.fl.v = as_ovf;
            end
            OP_AND, OP_TST: begin
                nx_d.res  = a & b;
                nx_d.fl.c = 1'b0;
                nx_d.fl.v = 1'b0;
            end
            OP_OR: begin
                nx_d.res  = a | b;
                nx_d.fl.c = 1'b0;
                nx_d.fl.v = 1'b0;
            end
            OP_NOT: nx_d.res = ~a;
            OP_BT, OP_BS, OP_BR, OP_BC: begin
                nx_d.res  = bo_res;
                nx_d.fl.c = bo_bit;
            end
            default: ;
        endcase
        if (op[3:2] != 2'b11) begin
            nx_d.fl.z = (nx_d.res == '0);
            nx_d.fl.s = nx_d.res[W-1];
        end
        if (op_e == OP_CMP || op_e == OP_TST || op_e == OP_BT)
            nx_d.wr = 1'b0;
        if (!en)
            nx_d.wr = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  flags_q <= '0;
        else if (en) flags_q <= nx_d.fl;
    end

    assign result = nx_d.res;
    assign wr_en  = nx_d.wr;
    assign flags  = flags_q;

    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(flags)) else $error("flags moved while idle"); // R10
    AST_INCDEC_KEEP_CV: assert property (@(posedge clk) disable iff (!rst_n)
        (en && (op == 4'd4 || op == 4'd5)) |=> (flags[0] == $past(flags[0]) && flags[3] == $past(flags[3])))
        else $error("inc/dec touched C or V"); // R3
    AST_LOGIC_CLR_CV: assert property (@(posedge clk) disable iff (!rst_n)
        (en && (op == 4'd7 || op == 4'd8 || op == 4'd9)) |=> (!flags[0] && !flags[3]))
        else $error("logic op left C or V"); // R5
    AST_NO_WB_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!en || op == 4'd6 || op == 4'd9 || op == 4'd12) |-> !wr_en)
        else $error("write-back without a result"); // R9
    AST_ZERO_FROM_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (en && op[3:2] != 2'b11) |=> (flags[1] == ($past(result) == '0)))
        else $error("zero flag mismatch"); // R8
    AST_BITOP_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (en && op[3:2] == 2'b11) |=> (flags[0] == $past(a[bit_idx]) && $stable(flags[3:1])))
        else $error("bit op flag rule broken"); // R7
endmodule

// File: tb/alu8_flags_bench.sv
module alu8_flags_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [3:0] op = '0;
    logic [7:0] a = '0, b = '0;
    logic [2:0] bit_idx = '0;
    logic [7:0] result;
    logic       wr_en;
    logic [3:0] flags;

    int n_tests = 0;
    int n_fail  = 0;
    logic [3:0] mflags = '0;
    bit done = 0;

    always #2 clk = ~clk;

    alu8_flags u_alu8_flags (
        .clk(clk), .rst_n(rst_n), .en(en), .op(op), .a(a), .b(b),
        .bit_idx(bit_idx), .result(result), .wr_en(wr_en), .flags(flags)
    );

    // returns {wr, V, S, Z, C, result}
    function automatic logic [12:0] model(input logic [7:0] x, input logic [7:0] y,
                                          input logic [3:0] o, input logic [2:0] ix,
                                          input logic [3:0] f);
        logic c, z, s, v, w;
        logic [8:0] t;
        logic [7:0] r, m;
        c = f[0]; z = f[1]; s = f[2]; v = f[3]; w = 1'b1;
        m = 8'h01 << ix;
        r = x;
        case (o)
            4'd0, 4'd1: begin
                t = {1'b0, x} + {1'b0, y} + ((o == 4'd1) ? {8'd0, f[0]} : 9'd0);
                r = t[7:0]; c = t[8]; v = (x[7] == y[7]) && (r[7] != x[7]);
            end
            4'd2, 4'd3, 4'd6: begin
                t = {1'b0, x} - {1'b0, y} - ((o == 4'd3) ? {8'd0, f[0]} : 9'd0);
                r = t[7:0]; c = t[8]; v = (x[7] != y[7]) && (r[7] != x[7]);
                if (o == 4'd6) w = 1'b0;
            end
            4'd4: r = x + 8'd1;
            4'd5: r = x - 8'd1;
            4'd7, 4'd9: begin r = x & y; c = 0; v = 0; if (o == 4'd9) w = 1'b0; end
            4'd8: begin r = x | y; c = 0; v = 0; end
            4'd10: r = ~x;
            4'd11: begin r = 8'd0 - x; c = (x != 0); v = (x == 8'h80); end
            default: begin
                c = x[ix];
                case (o)
                    4'd13: r = x | m;
                    4'd14: r = x & ~m;
                    4'd15: r = x ^ m;
                    default: begin r = x; w = 1'b0; end
                endcase
            end
        endcase
        if (o < 4'd12) begin z = (r == 0); s = r[7]; end
        return {w, v, s, z, c, r};
    endfunction

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic string req_of(input logic [3:0] o);
        case (o)
            4'd0, 4'd1: return "R1";
            4'd2, 4'd3: return "R2";
            4'd4, 4'd5: return "R3";
            4'd6: return "R4";
            4'd7, 4'd8, 4'd9: return "R5";
            4'd10, 4'd11: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic step(input logic e, input logic [3:0] o, input logic [7:0] x,
                        input logic [7:0] y, input logic [2:0] ix);
        logic [12:0] exp;
        string rq;
        @(negedge clk);
        en = e; op = o; a = x; b = y; bit_idx = ix;
        #1;
        exp = model(x, y, o, ix, mflags);
        rq = req_of(o);
        chk(rq, "result", result, exp[7:0]);
        chk(e ? "R9" : "R9 idle", "wr_en", {7'd0, wr_en}, {7'd0, exp[12] & e});
        @(posedge clk);
        #1;
        if (e) mflags = exp[11:8];
        chk(e ? {rq, "/R8/R11"} : "R10", "flags", {4'd0, flags}, {4'd0, mflags});
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (2) @(negedge clk);
        chk("R10", "reset flags", {4'd0, flags}, 8'h00);
        rst_n = 1'b1;
        // R1 carry out, zero, then signed overflow; ADC uses carry
        step(1, 4'd0, 8'hFF, 8'h01, 0);
        step(1, 4'd1, 8'h10, 8'h20, 0);
        step(1, 4'd0, 8'h7F, 8'h01, 0);
        // R2 borrow and SBB
        step(1, 4'd2, 8'h00, 8'h01, 0);
        step(1, 4'd3, 8'h05, 8'h02, 0);
        step(1, 4'd2, 8'h80, 8'h01, 0);
        // R3 inc/dec keep C,V: set C first
        step(1, 4'd2, 8'h00, 8'h01, 0);
        step(1, 4'd4, 8'hFF, 8'h00, 0);
        step(1, 4'd5, 8'h00, 8'h00, 0);
        // R4 compare equal / less / greater
        step(1, 4'd6, 8'h42, 8'h42, 0);
        step(1, 4'd6, 8'h10, 8'h90, 0);
        step(1, 4'd6, 8'hF0, 8'h0F, 0);
        // R5 OR with itself, test, and
        step(1, 4'd2, 8'h00, 8'hFF, 0);
        step(1, 4'd8, 8'h35, 8'h35, 0);
        chk("R5", "or-self clears all", {4'd0, flags}, 8'h00);
        step(1, 4'd9, 8'hF0, 8'h0F, 0);
        step(1, 4'd7, 8'hF3, 8'h8F, 0);
        // R6 not / neg corners
        step(1, 4'd10, 8'hFF, 8'h00, 0);
        step(1, 4'd11, 8'h80, 8'h00, 0);
        step(1, 4'd11, 8'h00, 8'h00, 0);
        // R7 bit ops at both ends
        step(1, 4'd12, 8'h80, 8'h00, 7);
        step(1, 4'd13, 8'h00, 8'h00, 0);
        step(1, 4'd14, 8'hFF, 8'h00, 7);
        step(1, 4'd15, 8'hA5, 8'h00, 3);
        // R10 hold when idle
        step(0, 4'd0, 8'hFF, 8'h01, 0);
        step(0, 4'd11, 8'h00, 8'h00, 0);
        for (int i = 0; i < 600; i++) begin
            step(($urandom % 8) != 0, 4'($urandom), 8'($urandom), 8'($urandom), 3'($urandom));
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule